// File: doc/BRIEF.md
# Retire-Counted Interrupt Injection Bank

This block is a bank of debug registers for test software. The software fires any of the processor's six hardware interrupt lines after a delay it chooses. Each line has its own countdown register. A 32-bit store of a non-zero delay arms that countdown. The countdown then loses one unit on every pulse of an instruction-retire strobe and never on an idle clock. When the last unit is consumed, the matching interrupt output rises and stays high until software writes that register again. The two software interrupt bits are not driven here.

The bank sits on a simple word bus with address, write data, write enable, read enable, a ready strobe and registered read data. It answers only inside a 32-byte window at base address 0x20010000. The countdown for line n is at byte offset 4*n, for n from 0 to 5. Offset 0x18 reports the vector of asserted lines. Several countdowns can be armed at once. When they run out on the same retire pulse, their lines rise together.

Top module: `irq_inject_bank`

## Requirements
- R1: A synchronous active-high reset clears every countdown to zero, disarms it, drives all six interrupt outputs low and leaves bus_ready low.
- R2: A write to word-aligned address 0x20010000 + 4*n (n = 0..5) loads the write data into countdown n. It arms that countdown when the data is non-zero, and it drives interrupt line n (bit n of irq_out) low in the next cycle.
- R3: An armed countdown decrements by one only in a cycle where retire is high. On cycles without retire, and on an unarmed countdown, the count stays unchanged.
- R4: After arming with delay d, line n rises in the cycle that follows the d-th retire pulse. It then stays high through any number of further retire pulses until register n is written again.
- R5: Writing zero to a countdown disarms it and deasserts its line. No later retire pulse asserts that line.
- R6: When a write to countdown n and a retire pulse fall in the same cycle, the written value is loaded and that retire pulse is not applied to line n.
- R7: A read of offset 4*n returns the remaining count of line n. A read of offset 0x18 returns the asserted lines in bits 5:0, with bit n standing for line n and bits 31:6 as zero. A read of offset 0x1C returns zero, and a write there has no effect.
- R8: An access outside the 32-byte window, or at an address with bits 1:0 non-zero, produces no ready pulse and changes no countdown and no line.
- R9: Countdowns that run out on the same retire pulse raise their lines in the same cycle.
- R10: bus_ready is high for exactly one cycle, the cycle after a bus read or write that hits the bank, and bus_rdata holds the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, one cycle per access |
| bus_re | input | 1 | Read enable, one cycle per access |
| bus_ready | output | 1 | Access acknowledge, one cycle after a hitting access |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| retire | input | 1 | One-cycle pulse per completed instruction |
| irq_out | output | 6 | Hardware interrupt lines, bit n for line n |

## Verification
A countdown that slips by even one unit shows at the ports as a line that rises one retire pulse early or late. A wrong count also shows on the next read of that register. A count that drifts on idle clocks shows up on the first read taken after a stretch with no retire pulses. The bench compares irq_out against its model on every cycle. A fault in the arming or the sticky hold therefore appears within the cycle it first occurs. A decode fault appears as a missing or extra ready pulse one cycle after the access.

// File: rtl/irq_inject_pkg.sv
package irq_inject_pkg;
  // Width of the word-index field used to select a register in the window.
  function automatic int idx_width(input int lines);
    return $clog2(lines + 2);
  endfunction
endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode #(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 6,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2001_0000,
  localparam int IDX_W   = irq_inject_pkg::idx_width(NUM_LINES),
  localparam int WIN_LSB = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [NUM_LINES-1:0] wr_sel
);
  logic in_window;

  always_comb begin
    in_window = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB])
                && (addr[1:0] == 2'b00);
    idx = addr[WIN_LSB-1:2];
    hit = in_window && (we || re);
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sel
    assign wr_sel[g] = in_window && we && (idx == IDX_W'(g));
  end

  // R2
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));
  // R8
  wr_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_sel != '0) |-> hit);
endmodule

// File: rtl/irq_countdown.sv
module irq_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             retire,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      armed <= 1'b0;
      irq   <= 1'b0;
    end else if (wr_en) begin
      count <= wr_val;
      armed <= (wr_val != '0);
      irq   <= 1'b0;
    end else if (armed && retire) begin
      count <= count - 1'b1;
      if (count == CNT_W'(1)) begin
        armed <= 1'b0;
        irq   <= 1'b1;
      end
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !retire) |=> ($stable(count) && $stable(irq)));
  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && retire && !wr_en && count > CNT_W'(1)) |=> (count == $past(count) - 1'b1) && !irq);
  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !wr_en) |=> irq);
  // R6
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (count == $past(wr_val)) && !irq);
endmodule

// File: rtl/irq_inject_bank.sv
module irq_inject_bank #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 6,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2001_0000,
  localparam int IDX_W = irq_inject_pkg::idx_width(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_we,
  input  logic                 bus_re,
  output logic                 bus_ready,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 retire,
  output logic [NUM_LINES-1:0] irq_out
);
  logic                 hit;
  logic [IDX_W-1:0]     idx;
  logic [NUM_LINES-1:0] wr_sel;
  logic [DATA_W-1:0]    counts [NUM_LINES];
  logic [DATA_W-1:0]    rd_mux;

  irq_bank_decode #(
    .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .re(bus_re),
    .hit(hit), .idx(idx), .wr_sel(wr_sel)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_countdown #(.CNT_W(DATA_W)) u_cnt (
      .clk(clk), .rst(rst), .wr_en(wr_sel[g]), .wr_val(bus_wdata),
      .retire(retire), .count(counts[g]), .irq(irq_out[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (int'(idx) < NUM_LINES)
      rd_mux = counts[idx];
    else if (int'(idx) == NUM_LINES)
      rd_mux = DATA_W'(irq_out);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= hit;
      bus_rdata <= (hit && bus_re) ? rd_mux : '0;
    end
  end

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_we || bus_re) && hit) |=> bus_ready);
  // R8
  no_ready_miss_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> !bus_ready);
  // R5
  zero_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && hit && bus_wdata == '0 && wr_sel != '0) |=> ((irq_out & $past(wr_sel)) == '0));
endmodule

// File: tb/irq_inject_bank_test.sv
module irq_inject_bank_test;
  localparam int N = 6;
  localparam logic [31:0] BASE = 32'h2001_0000;

  logic clk = 1'b0;
  logic rst;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic bus_we, bus_re, bus_ready, retire;
  logic [N-1:0] irq_out;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_cnt [N];
  logic [N-1:0] m_armed, m_irq;
  logic m_ready;
  logic [31:0] m_rdata;

  always #4 clk = ~clk;

  irq_inject_bank uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .retire(retire), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic in_bank(input logic [31:0] a);
    return (a[31:5] == BASE[31:5]) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] model_read(input logic [31:0] a);
    int k = int'(a[4:2]);
    if (k < N) return m_cnt[k];
    if (k == N) return {26'd0, m_irq};
    return 32'd0;
  endfunction

  // Advance the model by one clock edge with the current inputs.
  task automatic model_edge();
    logic hit = in_bank(bus_addr) && (bus_we || bus_re);
    m_ready = hit;
    m_rdata = (hit && bus_re) ? model_read(bus_addr) : 32'd0;
    for (int k = 0; k < N; k++) begin
      if (bus_we && in_bank(bus_addr) && int'(bus_addr[4:2]) == k) begin
        m_cnt[k] = bus_wdata;
        m_armed[k] = (bus_wdata != 0);
        m_irq[k] = 1'b0;
      end else if (m_armed[k] && retire) begin
        m_cnt[k] = m_cnt[k] - 1;
        if (m_cnt[k] == 0) begin
          m_armed[k] = 1'b0;
          m_irq[k] = 1'b1;
        end
      end
    end
  endtask

  // One cycle: drive at negedge, model at posedge, compare at next negedge.
  task automatic cyc(input logic we, input logic re, input logic [31:0] a,
                     input logic [31:0] d, input logic ret, input string req);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; retire = ret;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({req, " irq"}, {26'd0, irq_out}, {26'd0, m_irq});
    chk({req, " ready"}, {31'd0, bus_ready}, {31'd0, m_ready});
    if (m_ready && re) chk({req, " rdata"}, bus_rdata, m_rdata);
  endtask

  task automatic wr(input int k, input logic [31:0] d, input logic ret, input string req);
    cyc(1'b1, 1'b0, BASE + 32'(4 * k), d, ret, req);
  endtask

  task automatic rd(input int k, input string req);
    cyc(1'b0, 1'b1, BASE + 32'(4 * k), 32'd0, 1'b0, req);
  endtask

  task automatic idle(input logic ret, input string req);
    cyc(1'b0, 1'b0, 32'd0, 32'd0, ret, req);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < N; k++) m_cnt[k] = 0;
    m_armed = '0; m_irq = '0; m_ready = 0; m_rdata = 0;
    bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0; retire = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {26'd0, irq_out}, 32'd0);
    chk("R1 ready", {31'd0, bus_ready}, 32'd0);
    rd(0, "R1 count0");
    rd(N, "R1 vector");

    // R2 R3 R4: arm line 0 with 10, idle clocks do nothing
    wr(0, 32'd10, 1'b0, "R2 arm");
    repeat (5) idle(1'b0, "R3 idle");
    rd(0, "R3 count held");
    chk("R3 count value", bus_rdata, 32'd10);
    repeat (9) idle(1'b1, "R4 before expiry");
    chk("R4 not yet", {31'd0, irq_out[0]}, 32'd0);
    idle(1'b1, "R4 expiry");
    chk("R4 fired", {31'd0, irq_out[0]}, 32'd1);
    repeat (4) idle(1'b1, "R4 sticky");
    rd(N, "R7 vector");
    chk("R7 vector value", bus_rdata, 32'h1);
    wr(0, 32'd0, 1'b1, "R5 disarm");
    chk("R5 cleared", {31'd0, irq_out[0]}, 32'd0);
    repeat (5) idle(1'b1, "R5 stays low");

    // R9 simultaneous expiry of lines 1 and 3
    wr(1, 32'd3, 1'b0, "R9 arm1");
    wr(3, 32'd3, 1'b0, "R9 arm3");
    repeat (3) idle(1'b1, "R9 count");
    chk("R9 together", {26'd0, irq_out}, 32'h0A);

    // R6 write wins over retire
    wr(2, 32'd5, 1'b0, "R6 arm");
    wr(2, 32'd7, 1'b1, "R6 collide");
    rd(2, "R6 readback");
    chk("R6 value", bus_rdata, 32'd7);

    // R8 out-of-window and misaligned writes ignored
    cyc(1'b1, 1'b0, 32'h2002_0008, 32'd1, 1'b0, "R8 outside");
    cyc(1'b1, 1'b0, BASE + 32'h9, 32'd1, 1'b0, "R8 misaligned");
    rd(2, "R8 readback");
    chk("R8 value", bus_rdata, 32'd7);
    // R7 offset 0x1C
    cyc(1'b1, 1'b0, BASE + 32'h1C, 32'd3, 1'b0, "R7 spare write");
    cyc(1'b0, 1'b1, BASE + 32'h1C, 32'd0, 1'b0, "R7 spare read");
    chk("R7 spare zero", bus_rdata, 32'd0);

    // R10 and the rest: constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      int op = int'($urandom_range(0, 9));
      logic ret = ($urandom_range(0, 2) != 0);
      int k = int'($urandom_range(0, 7));
      if (op < 2) wr(k < N ? k : 0, 32'($urandom_range(0, 12)), ret, "R10 rand wr");
      else if (op < 4) cyc(1'b0, 1'b1, BASE + 32'(4 * k), 32'd0, 1'b0, "R7 rand rd");
      else if (op == 4) cyc(1'b1, 1'b0, 32'($urandom()), 32'($urandom_range(0, 9)), ret, "R8 rand addr");
      else idle(ret, "R3 rand idle");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule